// File: doc/BRIEF.md
# Serial Divider-Setting Loader

This block takes 23-bit control words that arrive over a three-wire serial link (shift clock, data, latch enable) and places each one into one of two holding latches for a frequency synthesizer. The three wires come from a slow, asynchronous host. They are brought into the system clock domain and edge-detected there. Bits enter a shift register on each rising edge of the shift clock, with the earliest bit ending up as the most significant bit. When latch enable rises, the most recent bit decides which latch takes the word.

A word whose final bit is 1 updates the feedback-divider latch. That latch holds a 13-bit main count, a 5-bit swallow count and a 2-bit output-control code. A word whose final bit is 0 updates the reference latch, which holds an 11-bit reference count and 2 test bits. Each transfer raises a one-cycle update strobe for the divider logic downstream. While latch enable stays high, the shift clock and data are ignored. A run-enable input gates the phase-output drive enable and never clears the latched settings.

The control FSM has three states. `ST_SHIFT` accepts bits while latch enable is low, and moves to `ST_LOAD` once latch enable is seen high. `ST_LOAD` lasts one cycle and issues the transfer, then always moves to `ST_HOLD`. `ST_HOLD` freezes the shift register and returns to `ST_SHIFT` once latch enable is seen low.

Top module: `pll_ctl_top`

## Requirements
- R1: Bits are sampled on rising shift-clock edges while latch enable is low, and the first bit of a word is its most significant bit (word bit 1 through word bit 23 in arrival order).
- R2: When latch enable rises and bit 23 is 1, the latch takes main count = bits 1..13 (bit 1 is its MSB), swallow count = bits 14..18, and output-control code = bits 21..22 (bit 21 is its MSB). Bits 19..20 are discarded. The stream 00001001110100010000111 gives main 314, swallow 4, code 11.
- R3: When latch enable rises and bit 23 is 0, the latch takes test bits = bits 8..9 (bit 8 is the MSB) and reference count = bits 10..20 (bit 10 is the MSB). Bits 1..7 and 21..22 are discarded. The stream 00000001000011000000000 gives reference 192 and test bits 10.
- R4: A transfer changes only the latch that bit 23 selects. The other latch keeps its contents.
- R5: While latch enable is high, shift-clock edges and data have no effect. Raising latch enable again with no new bits reloads the same word.
- R6: If more than 23 bits arrive before latch enable rises, only the last 23 are used.
- R7: Each rising edge of latch enable produces exactly one single-cycle `upd_stb`. It is asserted in the same cycle the new fields appear, and `upd_sel` gives bit 23 of that word.
- R8: `drive_en` is 1 only when the output-control code is 11 and `run_en` is 1. Codes 00, 01 and 10 give 0.
- R9: Setting `run_en` low forces `drive_en` to 0 and leaves every latched field unchanged. Setting it high again restores the previous drive state.
- R10: After reset every latched field is 0, and `upd_stb` and `drive_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Operate (1) / standby (0) |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Latch enable, asynchronous |
| main_cnt | output | 13 | Latched main count |
| swal_cnt | output | 5 | Latched swallow count |
| out_ctl | output | 2 | Latched output-control code |
| drive_en | output | 1 | Phase output driven (1) or floating (0) |
| ref_cnt | output | 11 | Latched reference count |
| test_bits | output | 2 | Latched test bits |
| upd_stb | output | 1 | One-cycle transfer strobe |
| upd_sel | output | 1 | Latch that the last transfer targeted (1 = divider) |

## Verification
On every cycle, the assertions check the following:
- the load state lasts a single cycle;
- the shift register stays frozen outside the shift state;
- the strobe is one cycle wide;
- a latch changes only in a cycle that strobes for that latch.

Field placement, bit order and the reference examples can only be shown by the bench's scenarios, which push expected words into a scoreboard. The same holds for dropping extra leading bits, reloading a frozen word, decoding the drive code, and retaining data in standby.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
    parameter int MAIN_W  = 13;
    parameter int SWAL_W  = 5;
    parameter int REF_W   = 11;
    parameter int CTL_W   = 2;
    parameter int TEST_W  = 2;
    parameter int SPARE_W = 2;
    // word = main + swallow + spare + control + select
    localparam int WORD_W = MAIN_W + SWAL_W + SPARE_W + CTL_W + 1;

    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_LOAD  = 2'd1,
        ST_HOLD  = 2'd2
    } ld_state_t;
endpackage

// File: rtl/pll_ctl_sync.sv
module pll_ctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic lvl,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], d};
    end

    assign lvl  = sh_q[STAGES-1];
    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pll_ctl_fsm.sv
module pll_ctl_fsm
    import pll_ctl_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_rise,
    input  logic         sdat_lvl,
    input  logic         le_lvl,
    output logic [W-1:0] word,
    output logic         load
);
    ld_state_t state_q, state_d;
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHIFT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHIFT: if (le_lvl)  state_d = ST_LOAD;
            ST_LOAD:               state_d = ST_HOLD;
            ST_HOLD:  if (!le_lvl) state_d = ST_SHIFT;
            default:               state_d = ST_SHIFT;
        endcase
    end

    // shift only in ST_SHIFT with latch enable still low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else if (state_q == ST_SHIFT && !le_lvl && sclk_rise)
            sr_q <= {sr_q[W-2:0], sdat_lvl};
    end

    assign load = (state_q == ST_LOAD);
    assign word = sr_q;

    p_load_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q == ST_HOLD));
    p_frozen_when_le_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT) |=> $stable(sr_q));
endmodule

// File: rtl/pll_ctl_latch.sv
module pll_ctl_latch
    import pll_ctl_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [W-1:0]      word,
    output logic [MAIN_W-1:0] main_q,
    output logic [SWAL_W-1:0] swal_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [REF_W-1:0]  ref_q,
    output logic [TEST_W-1:0] test_q,
    output logic              stb_q,
    output logic              sel_q
);
    localparam int CTL_LO  = 1;
    localparam int SWAL_LO = CTL_LO + CTL_W + SPARE_W;
    localparam int MAIN_LO = SWAL_LO + SWAL_W;
    localparam int REF_LO  = CTL_LO + CTL_W;
    localparam int TEST_LO = REF_LO + REF_W;

    logic sel_w;
    assign sel_w = word[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0; swal_q <= '0; ctl_q  <= '0;
            ref_q  <= '0; test_q <= '0; stb_q  <= 1'b0; sel_q <= 1'b0;
        end else begin
            stb_q <= load;
            if (load) begin
                sel_q <= sel_w;
                if (sel_w) begin
                    main_q <= word[MAIN_LO +: MAIN_W];
                    swal_q <= word[SWAL_LO +: SWAL_W];
                    ctl_q  <= word[CTL_LO  +: CTL_W];
                end else begin
                    ref_q  <= word[REF_LO  +: REF_W];
                    test_q <= word[TEST_LO +: TEST_W];
                end
            end
        end
    end

    p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);
    p_div_only_on_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({main_q, swal_q, ctl_q}) |-> (stb_q && sel_q));
    p_ref_only_on_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ref_q, test_q}) |-> (stb_q && !sel_q));
endmodule

// File: rtl/pll_ctl_top.sv
module pll_ctl_top
    import pll_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    output logic [MAIN_W-1:0] main_cnt,
    output logic [SWAL_W-1:0] swal_cnt,
    output logic [CTL_W-1:0]  out_ctl,
    output logic              drive_en,
    output logic [REF_W-1:0]  ref_cnt,
    output logic [TEST_W-1:0] test_bits,
    output logic              upd_stb,
    output logic              upd_sel
);
    localparam int NSIG = 3;
    localparam logic [CTL_W-1:0] CTL_DRIVE = '1;

    logic [NSIG-1:0] raw, lvl, rise;
    logic [WORD_W-1:0] word;
    logic load;

    assign raw = {ser_le, ser_dat, ser_clk};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        pll_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw[g]), .lvl(lvl[g]), .rise(rise[g]));
    end

    pll_ctl_fsm #(.W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sclk_rise(rise[0]), .sdat_lvl(lvl[1]),
        .le_lvl(lvl[2]), .word(word), .load(load));

    pll_ctl_latch #(.W(WORD_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(load), .word(word),
        .main_q(main_cnt), .swal_q(swal_cnt), .ctl_q(out_ctl),
        .ref_q(ref_cnt), .test_q(test_bits), .stb_q(upd_stb), .sel_q(upd_sel));

    assign drive_en = run_en && (out_ctl == CTL_DRIVE);

    p_standby_floats_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !drive_en);
endmodule

// File: tb/pll_ctl_top_tb_top.sv
module pll_ctl_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [12:0] main_cnt;
    logic [4:0]  swal_cnt;
    logic [1:0]  out_ctl, test_bits;
    logic [10:0] ref_cnt;
    logic drive_en, upd_stb, upd_sel;

    always #10 clk = ~clk; // 50 MHz

    pll_ctl_top dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_le(ser_le), .main_cnt(main_cnt),
        .swal_cnt(swal_cnt), .out_ctl(out_ctl), .drive_en(drive_en),
        .ref_cnt(ref_cnt), .test_bits(test_bits), .upd_stb(upd_stb),
        .upd_sel(upd_sel));

    typedef struct packed {
        logic        sel;
        logic [12:0] m;
        logic [4:0]  s;
        logic [1:0]  c;
        logic [10:0] r;
        logic [1:0]  t;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur = '0;
    logic [22:0] exp_sr = '0;
    int checks = 0, fails = 0, strobes = 0, pushes = 0;
    bit prev_stb = 1'b0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: shifts n bits MSB first
    task automatic send_bits(input logic [22:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = w[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            exp_sr = {exp_sr[21:0], w[i]};
            wait_cyc(4);
            ser_clk = 1'b0;
        end
    endtask

    // driver: latch pulse; expected word decoded from R2/R3 field positions
    task automatic latch_pulse(input bit noise);
        exp_t e;
        e = cur;
        e.sel = exp_sr[0];
        if (exp_sr[0]) begin
            e.m = exp_sr[22:10];
            e.s = exp_sr[9:5];
            e.c = exp_sr[2:1];
        end else begin
            e.t = exp_sr[15:14];
            e.r = exp_sr[13:3];
        end
        cur = e;
        exp_q.push_back(e);
        pushes++;
        ser_le = 1'b1;
        wait_cyc(8);
        if (noise) begin
            for (int k = 0; k < 4; k++) begin
                ser_dat = ~ser_dat;
                wait_cyc(3);
                ser_clk = 1'b1;
                wait_cyc(3);
                ser_clk = 1'b0;
            end
        end
        ser_le = 1'b0;
        wait_cyc(8);
    endtask

    task automatic send_word(input logic [22:0] w);
        send_bits(w, 23);
        latch_pulse(1'b0);
    endtask

    // monitor: pops expected items on each strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (upd_stb) begin
                exp_t e;
                strobes++;
                if (prev_stb) chk("R7 strobe width", 1, 0);
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected strobe", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R7 upd_sel", upd_sel, e.sel);
                    chk("R2 main_cnt", main_cnt, e.m);
                    chk("R2 swal_cnt", swal_cnt, e.s);
                    chk("R2 out_ctl", out_ctl, e.c);
                    chk("R3 ref_cnt", ref_cnt, e.r);
                    chk("R3 test_bits", test_bits, e.t);
                end
            end
            prev_stb = upd_stb;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        // R10 reset state
        chk("R10 main_cnt", main_cnt, 0);
        chk("R10 ref_cnt", ref_cnt, 0);
        chk("R10 upd_stb", upd_stb, 0);
        chk("R10 drive_en", drive_en, 0);

        // R1/R2 divider example stream
        send_word(23'b00001001110100010000111);
        chk("R2 main 314", main_cnt, 314);
        chk("R2 swallow 4", swal_cnt, 4);
        chk("R8 drive on 11", drive_en, 1);

        // R3 reference example; R4 divider untouched
        send_word(23'b00000001000011000000000);
        chk("R3 ref 192", ref_cnt, 192);
        chk("R3 test 10", test_bits, 2);
        chk("R4 main kept", main_cnt, 314);

        // R8 other codes
        send_word({13'd1000, 5'd17, 2'b00, 2'b01, 1'b1});
        chk("R8 code 01", drive_en, 0);
        chk("R4 ref kept", ref_cnt, 192);
        send_word({13'd8191, 5'd31, 2'b11, 2'b10, 1'b1});
        chk("R8 code 10", drive_en, 0);
        send_word({13'd32, 5'd0, 2'b00, 2'b00, 1'b1});
        chk("R8 code 00", drive_en, 0);

        // R9 standby keeps data
        send_word({13'd4660, 5'd9, 2'b00, 2'b11, 1'b1});
        chk("R8 code 11", drive_en, 1);
        run_en = 1'b0;
        wait_cyc(10);
        chk("R9 drive off", drive_en, 0);
        chk("R9 main kept", main_cnt, 4660);
        chk("R9 ref kept", ref_cnt, 192);
        run_en = 1'b1;
        wait_cyc(4);
        chk("R9 drive back", drive_en, 1);

        // R5 clocks ignored while latch enable high, then reload same word
        send_bits({7'd0, 2'b01, 11'd2047, 2'b00, 1'b0}, 23);
        latch_pulse(1'b1);
        latch_pulse(1'b0);
        chk("R5 ref reload", ref_cnt, 2047);
        chk("R5 test reload", test_bits, 1);

        // R6 extra leading bits discarded
        send_bits(23'h3, 2);
        send_word({13'd555, 5'd21, 2'b00, 2'b11, 1'b1});
        chk("R6 main", main_cnt, 555);
        chk("R6 swallow", swal_cnt, 21);

        wait_cyc(20);
        chk("R7 all strobes seen", exp_q.size(), 0);
        chk("R7 strobe count", strobes, pushes);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule